// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block copies a run of consecutive words between one peripheral and memory. Software uses it by loading three parameters through memory-mapped registers: the first memory word address, the number of words, and which way the data flows. A separate command write then starts the transfer. The engine does the rest by itself. It fetches one word from the source side and holds it, then stores it on the destination side, and repeats this until the word count runs out.

Each side has its own request/acknowledge handshake, and the engine drives the request on both. On the memory side the engine also supplies the word address and a write enable. When the last word has been stored, the engine returns to idle and sets a sticky done flag. That flag is the block's only interrupt, so there is one interrupt per block and not one per word. Software clears the flag by writing a one to a clear bit.

Top module: `dma_block_mover`

## Requirements
- R1: After reset, `irq` is low, both request outputs are low, and all four register offsets read as zero.
- R2: While idle, the programmed values can be read back. Offset 0 holds the memory word address. Offset 1 holds the word count. Offset 2 bit 0 holds the direction, where 0 is peripheral-to-memory and 1 is memory-to-peripheral.
- R3: Writing the parameters does not start a transfer. A transfer starts only when offset 3 is written with bit 0 set. While idle, neither request is asserted.
- R4: In peripheral-to-memory mode, each word is first read from the peripheral (`pdev_req` with `pdev_wr`=0) and then written to memory (`mem_req` with `mem_we`=1). Word k goes to address start+k and carries the k-th word the peripheral delivered.
- R5: In memory-to-peripheral mode, each word is first read from memory at address start+k (`mem_we`=0) and then written to the peripheral (`pdev_wr`=1) with the same data.
- R6: A request stays high, with its address and direction held steady, until its acknowledge is seen. The memory request and the peripheral request are never high in the same cycle.
- R7: Each memory beat advances the working address by one. Each stored word lowers the remaining count by one. After completion, offset 0 reads start+count and offset 1 reads zero.
- R8: Exactly one rising edge of `irq` occurs per block, in the cycle after the last store acknowledge. `irq` then stays high, and the status at offset 3 shows busy (bit 0) as 0 and done (bit 1) as 1.
- R9: Writing offset 3 with bit 1 set clears the done flag and lowers `irq`. If completion happens in the same cycle, completion wins.
- R10: While busy, a start command is ignored, and so are writes to offsets 0, 1 and 2. The running block completes unchanged.
- R11: A start command with a count of zero sets done and raises `irq` on the next cycle. It makes no memory or peripheral access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory beat acknowledge |
| pdev_req | output | 1 | Peripheral transfer request |
| pdev_wr | output | 1 | Engine delivers to the peripheral (1) or takes from it (0) |
| pdev_wdata | output | DATA_W | Data delivered to the peripheral |
| pdev_rdata | input | DATA_W | Data from the peripheral, valid with `pdev_ack` |
| pdev_ack | input | 1 | Peripheral acknowledge |
| irq | output | 1 | Sticky block completion interrupt |

## Verification
A corrupted address counter shows on `mem_addr` at the very next memory beat. It also shows in the final address readback. A corrupted count or sequencer state shows as the wrong number of beats on either handshake, or as `irq` rising early, late, or more than once per block. The bench checks every beat's address and data against values it computes itself. It changes the acknowledge latency at random, so a handshake that ignores a late acknowledge shows up within one word.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 2;

    localparam logic [OFS_W-1:0] OFS_ADDR = 2'd0;
    localparam logic [OFS_W-1:0] OFS_LEN  = 2'd1;
    localparam logic [OFS_W-1:0] OFS_MODE = 2'd2;
    localparam logic [OFS_W-1:0] OFS_CMD  = 2'd3;

    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_CLR_BIT  = 1;
    localparam int STS_BUSY_BIT = 0;
    localparam int STS_DONE_BIT = 1;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_FETCH = 2'd1,
        XF_STORE = 2'd2
    } xfer_state_e;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic ld_addr;
        logic ld_len;
        logic ld_mode;
        logic go;
        logic clr_done;
    } reg_strobe_t;

    function automatic logic hits(input logic wr, input logic [OFS_W-1:0] a,
                                  input logic [OFS_W-1:0] ofs);
        return wr && (a == ofs);
    endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 busy,
    input  logic                 done_set,
    input  logic [ADDR_W-1:0]    cur_addr,
    input  logic [LEN_W-1:0]     cur_len,
    output reg_strobe_t          strb,
    output xfer_dir_e            dir_q,
    output logic                 done_q,
    output logic [REG_W-1:0]     reg_rdata
);

    // parameter writes and start are refused while a block runs
    always_comb begin
        strb          = '0;
        strb.ld_addr  = hits(reg_wr, reg_addr, OFS_ADDR) && !busy;
        strb.ld_len   = hits(reg_wr, reg_addr, OFS_LEN)  && !busy;
        strb.ld_mode  = hits(reg_wr, reg_addr, OFS_MODE) && !busy;
        strb.go       = hits(reg_wr, reg_addr, OFS_CMD)  && !busy && reg_wdata[CMD_GO_BIT];
        strb.clr_done = hits(reg_wr, reg_addr, OFS_CMD)  && reg_wdata[CMD_CLR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= DIR_DEV2MEM;
            done_q <= 1'b0;
        end else begin
            if (strb.ld_mode)
                dir_q <= xfer_dir_e'(reg_wdata[0]);
            // completion has priority over a software clear
            if (done_set)
                done_q <= 1'b1;
            else if (strb.clr_done)
                done_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_ADDR: reg_rdata[ADDR_W-1:0] = cur_addr;
            OFS_LEN:  reg_rdata[LEN_W-1:0]  = cur_len;
            OFS_MODE: reg_rdata[0]          = dir_q;
            default: begin
                reg_rdata[STS_BUSY_BIT] = busy;
                reg_rdata[STS_DONE_BIT] = done_q;
            end
        endcase
    end

endmodule

// File: rtl/dma_walk_ctr.sv
module dma_walk_ctr #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_len,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              step_addr,
    input  logic              step_len,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              len_zero,
    output logic              len_one
);

    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  LEN_DEC  = LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            len_q  <= '0;
        end else begin
            if (ld_addr)
                addr_q <= addr_in;
            else if (step_addr)
                addr_q <= addr_q + ADDR_INC;

            if (ld_len)
                len_q <= len_in;
            else if (step_len && !len_zero)
                len_q <= len_q - LEN_DEC;
        end
    end

    assign len_zero = (len_q == '0);
    assign len_one  = (len_q == LEN_DEC);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  xfer_dir_e         dir,
    input  logic              len_zero,
    input  logic              len_one,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              pdev_ack,
    input  logic [DATA_W-1:0] pdev_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              pdev_req,
    output logic              pdev_wr,
    output logic [DATA_W-1:0] hold_data,
    output logic              step_addr,
    output logic              step_len,
    output logic              done_set
);

    xfer_state_e st_q, st_d;
    logic        to_dev, in_fetch, in_store, src_done, dst_done;

    assign to_dev   = (dir == DIR_MEM2DEV);
    assign in_fetch = (st_q == XF_FETCH);
    assign in_store = (st_q == XF_STORE);
    assign busy     = (st_q != XF_IDLE);

    // source side is fetched first, destination side stored second
    assign mem_req  = (in_fetch && to_dev) || (in_store && !to_dev);
    assign pdev_req = (in_fetch && !to_dev) || (in_store && to_dev);
    assign mem_we   = !to_dev;
    assign pdev_wr  = to_dev;

    assign src_done = in_fetch && (to_dev ? mem_ack : pdev_ack);
    assign dst_done = in_store && (to_dev ? pdev_ack : mem_ack);

    assign step_addr = mem_req && mem_ack;
    assign step_len  = dst_done;
    assign done_set  = (!busy && go && len_zero) || (dst_done && len_one);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XF_IDLE:  if (go && !len_zero) st_d = XF_FETCH;
            XF_FETCH: if (src_done)        st_d = XF_STORE;
            XF_STORE: if (dst_done)        st_d = len_one ? XF_IDLE : XF_FETCH;
            default:                       st_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= XF_IDLE;
            hold_data <= '0;
        end else begin
            st_q <= st_d;
            if (src_done)
                hold_data <= to_dev ? mem_rdata : pdev_rdata;
        end
    end

endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              pdev_req,
    output logic              pdev_wr,
    output logic [DATA_W-1:0] pdev_wdata,
    input  logic [DATA_W-1:0] pdev_rdata,
    input  logic              pdev_ack,
    output logic              irq
);

    reg_strobe_t       strb;
    xfer_dir_e         dir_q;
    logic              done_q, busy, done_set;
    logic              step_addr, step_len, len_zero, len_one;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_len;
    logic [DATA_W-1:0] hold_data;

    dma_reg_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .done_set  (done_set),
        .cur_addr  (cur_addr),
        .cur_len   (cur_len),
        .strb      (strb),
        .dir_q     (dir_q),
        .done_q    (done_q),
        .reg_rdata (reg_rdata)
    );

    dma_walk_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .ld_addr   (strb.ld_addr),
        .ld_len    (strb.ld_len),
        .addr_in   (reg_wdata[ADDR_W-1:0]),
        .len_in    (reg_wdata[LEN_W-1:0]),
        .step_addr (step_addr),
        .step_len  (step_len),
        .addr_q    (cur_addr),
        .len_q     (cur_len),
        .len_zero  (len_zero),
        .len_one   (len_one)
    );

    dma_xfer_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (strb.go),
        .dir        (dir_q),
        .len_zero   (len_zero),
        .len_one    (len_one),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .pdev_ack   (pdev_ack),
        .pdev_rdata (pdev_rdata),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .pdev_req   (pdev_req),
        .pdev_wr    (pdev_wr),
        .hold_data  (hold_data),
        .step_addr  (step_addr),
        .step_len   (step_len),
        .done_set   (done_set)
    );

    assign mem_addr   = cur_addr;
    assign mem_wdata  = hold_data;
    assign pdev_wdata = hold_data;
    assign irq        = done_q;

endmodule

// File: rtl/dma_block_mover_chk.sv
module dma_block_mover_chk #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_wr,
    input logic              go_bit,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pdev_req,
    input logic              pdev_wr,
    input logic              pdev_ack,
    input logic              irq,
    input logic              busy,
    input logic [LEN_W-1:0]  cur_len
);

    p_one_side_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && pdev_req));

    p_mem_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_pdev_hold_r6: assert property (@(posedge clk) disable iff (rst)
        pdev_req && !pdev_ack |=> pdev_req && $stable(pdev_wr));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !pdev_req);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> mem_addr == $past(mem_addr) + 1'b1);

    p_len_step_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_we) || (pdev_req && pdev_ack && pdev_wr)
        |=> cur_len == $past(cur_len) - 1'b1);

    p_len_floor_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> cur_len != '0);

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        irq && !clr_wr |=> irq);

    p_irq_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_wr && !go_bit && !busy |=> !irq);

endmodule

bind dma_block_mover dma_block_mover_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_wr   (reg_wr && (reg_addr == dma_pkg::OFS_CMD) && reg_wdata[dma_pkg::CMD_CLR_BIT]),
    .go_bit   (reg_wdata[dma_pkg::CMD_GO_BIT]),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .pdev_req (pdev_req),
    .pdev_wr  (pdev_wr),
    .pdev_ack (pdev_ack),
    .irq      (irq),
    .busy     (busy),
    .cur_len  (cur_len)
);

// File: tb/dma_block_mover_test.sv
module dma_block_mover_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LOGN = 1024;
    localparam int SEED = 20240611;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we, pdev_req, pdev_wr, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, pdev_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] pdev_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          pdev_ack = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int mem_beats = 0, pbeats = 0, overlap = 0, irq_rises = 0;
    int mwait = 0, pwait = 0;
    logic irq_d = 1'b0;
    logic [AW-1:0] mlog_addr [LOGN];
    logic [DW-1:0] mlog_data [LOGN];
    logic [DW-1:0] plog_data [LOGN];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_block_mover uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .pdev_req(pdev_req), .pdev_wr(pdev_wr), .pdev_wdata(pdev_wdata),
        .pdev_rdata(pdev_rdata), .pdev_ack(pdev_ack), .irq(irq)
    );

    function automatic logic [DW-1:0] mem_init(input logic [AW-1:0] a);
        return {~a, a} ^ 32'h3C3C_0F0F;
    endfunction

    function automatic logic [DW-1:0] dev_word(input int k);
        return 32'hC0DE_0000 ^ (k * 32'h0001_0003);
    endfunction

    // memory responder: random latency, one-cycle acknowledge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            mwait = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (mwait != 0) mwait = mwait - 1;
            else begin
                mem_ack = 1'b1;
                mlog_addr[mem_beats % LOGN] = mem_addr;
                if (mem_we) mlog_data[mem_beats % LOGN] = mem_wdata;
                else mem_rdata = mem_init(mem_addr);
                mem_beats = mem_beats + 1;
                mwait = $urandom_range(0, 3);
            end
        end
    end

    // peripheral responder
    always @(negedge clk) begin
        if (rst) begin
            pdev_ack = 1'b0;
            pwait = 0;
        end else if (pdev_ack) begin
            pdev_ack = 1'b0;
        end else if (pdev_req) begin
            if (pwait != 0) pwait = pwait - 1;
            else begin
                pdev_ack = 1'b1;
                if (pdev_wr) plog_data[pbeats % LOGN] = pdev_wdata;
                else pdev_rdata = dev_word(pbeats);
                pbeats = pbeats + 1;
                pwait = $urandom_range(0, 4);
            end
        end
    end

    always @(negedge clk) begin
        if (mem_req && pdev_req) overlap = overlap + 1;
        if (irq && !irq_d) irq_rises = irq_rises + 1;
        irq_d = irq;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] ofs, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ofs; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] ofs, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ofs;
        #1 d = reg_rdata;
    endtask

    task automatic run_block(input int start, input int len, input bit to_dev, input bit disturb);
        int base_m, base_p, base_i, cyc;
        logic [31:0] rd;
        base_m = mem_beats; base_p = pbeats; base_i = irq_rises;
        reg_write(2'd0, start);
        reg_write(2'd1, len);
        reg_write(2'd2, {31'd0, to_dev});
        reg_write(2'd3, 32'd1);
        if (disturb) begin
            // R10: all of these must be ignored while busy
            reg_write(2'd3, 32'd1);
            reg_write(2'd0, 32'h0300);
            reg_write(2'd1, 32'd5);
            reg_write(2'd2, {31'd0, !to_dev});
        end
        cyc = 0;
        while (!irq && cyc < 5000) begin @(negedge clk); cyc++; end
        check("R8 irq raised at block end", {31'd0, irq}, 32'd1);
        check("R4/R5 memory beat count", mem_beats - base_m, len);
        check("R4/R5 peripheral beat count", pbeats - base_p, len);
        for (int k = 0; k < len; k++) begin
            check("R4/R5 memory address", {16'd0, mlog_addr[(base_m + k) % LOGN]}, 32'((start + k) & 16'hFFFF));
            if (to_dev)
                check("R5 peripheral data", plog_data[(base_p + k) % LOGN], mem_init(16'((start + k) & 16'hFFFF)));
            else
                check("R4 memory data", mlog_data[(base_m + k) % LOGN], dev_word(base_p + k));
        end
        reg_read(2'd0, rd);
        check("R7 final address", rd, 32'((start + len) & 16'hFFFF));
        reg_read(2'd1, rd);
        check("R7 final count", rd, 32'd0);
        reg_read(2'd2, rd);
        check("R10 mode kept", rd, {31'd0, to_dev});
        reg_read(2'd3, rd);
        check("R8 status done not busy", rd, 32'd2);
        repeat (3) @(negedge clk);
        check("R8 single irq edge", irq_rises - base_i, 32'd1);
        check("R8 irq sticky", {31'd0, irq}, 32'd1);
        reg_write(2'd3, 32'd2);
        check("R9 irq cleared", {31'd0, irq}, 32'd0);
        reg_read(2'd3, rd);
        check("R9 status cleared", rd, 32'd0);
    endtask

    initial begin
        logic [31:0] rd;
        int base_m, base_p;
        void'($urandom(SEED));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 requests after reset", {30'd0, mem_req, pdev_req}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            reg_read(i[1:0], rd);
            check("R1 register reset value", rd, 32'd0);
        end

        // R2 and R3: program without a start
        base_m = mem_beats; base_p = pbeats;
        reg_write(2'd0, 32'h0123);
        reg_write(2'd1, 32'd7);
        reg_write(2'd2, 32'd1);
        reg_write(2'd3, 32'd0);
        reg_read(2'd0, rd); check("R2 address readback", rd, 32'h0123);
        reg_read(2'd1, rd); check("R2 count readback", rd, 32'd7);
        reg_read(2'd2, rd); check("R2 mode readback", rd, 32'd1);
        repeat (10) @(negedge clk);
        check("R3 no access without start", mem_beats + pbeats - base_m - base_p, 32'd0);
        reg_read(2'd3, rd); check("R3 not busy", rd, 32'd0);

        // directed blocks
        run_block(32'h0040, 4, 1'b0, 1'b0);
        run_block(32'h0100, 1, 1'b1, 1'b0);
        run_block(32'hFFFE, 3, 1'b1, 1'b0);
        run_block(32'h0200, 12, 1'b0, 1'b1);
        run_block(32'h0280, 12, 1'b1, 1'b1);

        // R11: zero length
        base_m = mem_beats; base_p = pbeats;
        reg_write(2'd0, 32'h0055);
        reg_write(2'd1, 32'd0);
        reg_write(2'd3, 32'd1);
        check("R11 irq on zero count", {31'd0, irq}, 32'd1);
        repeat (5) @(negedge clk);
        check("R11 no accesses", mem_beats + pbeats - base_m - base_p, 32'd0);
        reg_read(2'd3, rd); check("R11 status done", rd, 32'd2);
        reg_read(2'd0, rd); check("R11 address unchanged", rd, 32'h0055);
        reg_write(2'd3, 32'd2);
        check("R9 clear after zero block", {31'd0, irq}, 32'd0);

        // random blocks
        for (int n = 0; n < 8; n++)
            run_block($urandom_range(0, 32'hFFFF), $urandom_range(1, 24), 1'($urandom_range(0, 1)), 1'b0);

        check("R6 requests never overlap", overlap, 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog R8: actual no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule